// File: doc/BRIEF.md
# SPI Command Decoder with Register File

This block is the serial command front end of a data converter. A host talks to it over an SPI slave port in mode 1: the block captures MOSI on the falling edge of SCLK and moves MISO after the rising edge. All SPI pins pass through a two-stage synchronizer into the system clock domain. Command bytes are decoded by one byte-level state machine. That machine serves burst reads and burst writes of a small register file, and it shifts out 24-bit conversion results either on request or in a continuous mode.

The converter side delivers each new result through a one-cycle strobe with the data word. A level flag marks the period while a result is being rewritten. The block drives an active-low data-ready output from these inputs and from the progress of the host's readout. All register contents are presented as a flat vector to the analog and filter logic, which lie outside this block.

State machine. The states are `ST_CMD` (receive a command byte), `ST_CNT` (receive the count byte), `ST_WR` (receive write data bytes), `ST_RD` (send register bytes) and `ST_RES` (send result bits). The named transitions are:
- *open-burst*: `ST_CMD`→`ST_CNT` on a read or write opcode.
- *count-read*: `ST_CNT`→`ST_RD`.
- *count-write*: `ST_CNT`→`ST_WR`.
- *burst-end*: `ST_RD`/`ST_WR`→`ST_CMD` after the last byte.
- *read-result*: `ST_CMD`→`ST_RES` on the read-once opcode.
- *auto-result*: `ST_CMD`→`ST_RES` at the first rising SCLK of a byte, when continuous mode is on and a result is pending.
- *result-end*: `ST_RES`→`ST_CMD` after bit 24.
- *update-abort*: `ST_RES`→`ST_CMD` while the updating flag is high.
- *deselect*: any state→`ST_CMD` with the bit counter cleared while chip select is high.

Top module: `spi_cmd_regfile`

## Requirements
- R1: After reset, data_ready_n is 1 and MISO is 0. Register 3 (data rate) holds F0h and all other registers hold 00h.
- R2: In SPI mode 1, MOSI is captured on the falling SCLK edge and MISO changes after the rising edge. Command and register bytes travel MSB first. Raising chip select discards a partly received byte and clears the bit counter.
- R3: Command byte 0001 aaaa followed by count byte n returns n+1 registers starting at address aaaa, with at most 11 registers. Once the burst ends, the next byte is a new command, and MISO stays 0 during it.
- R4: Burst addresses wrap from register 10 to register 0. A start address of 11 to 15 begins at register 0.
- R5: Command byte 0101 aaaa followed by count byte n writes the next n+1 data bytes to consecutive registers starting at aaaa.
- R6: A result strobe stores the word and drives data_ready_n low on the next cycle.
- R7: Command byte 01h shifts out the stored 24-bit result on the next 24 SCLK cycles. data_ready_n returns high once bit 24 has been clocked.
- R8: While the updating flag is high, data_ready_n is high and any pending result is dropped.
- R9: Bit 3 of register 0 sets the result bit order: 0 sends the MSB first, 1 sends the LSB first.
- R10: Command byte 03h enters continuous mode. Each pending result is then shifted out on the next 24 SCLK cycles without a command, and data_ready_n returns high after bit 24.
- R11: In continuous mode, if fewer than 24 bits are read, data_ready_n stays low until the next update. The next result is shifted from its first bit.
- R12: Command byte 0Fh leaves continuous mode when no result is pending. Command bytes with no defined meaning change no register and produce no output.
- R13: If a result strobe falls in the same cycle as the completion of bit 24, the new result stays pending and data_ready_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| res_valid | input | 1 | One-cycle strobe: a new result is on res_data |
| res_data | input | 24 | Conversion result word |
| res_updating | input | 1 | High while the result is being rewritten |
| data_ready_n | output | 1 | Low while an unread result is pending |
| cfg_regs | output | 88 | All registers, register k at bits 8k+7:8k |

## Verification
The completion of the 24th result bit and the arrival of a new result strobe can land in the same clock cycle. One clears the pending flag and the other sets it. The bench provokes this by placing the strobe exactly two clock cycles after it drops SCLK for the last result bit, since that is the cycle in which the synchronized falling edge is acted on. The outcome is judged at the ports: data_ready_n must remain low, and a following read-once command must return the new word.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_CNT,
        ST_WR,
        ST_RD,
        ST_RES
    } fsm_state_t;

    localparam logic [3:0] OPH_RREG   = 4'h1;
    localparam logic [3:0] OPH_WREG   = 4'h5;
    localparam logic [7:0] OP_RDATA   = 8'h01;
    localparam logic [7:0] OP_RDATAC  = 8'h03;
    localparam logic [7:0] OP_SDATAC  = 8'h0F;

    localparam int         ORDER_BIT  = 3;
    localparam int         RATE_ADDR  = 3;
    localparam logic [7:0] RATE_RST   = 8'hF0;

    function automatic logic [7:0] reg_rst_val(input int addr);
        return (addr == RATE_ADDR) ? RATE_RST : 8'h00;
    endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
    import spi_cmd_pkg::*;
#(
    parameter int NREG = 11,
    parameter int AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_byte,
    output logic [NREG*8-1:0] regs_flat
);

    logic [7:0] mem_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= reg_rst_val(g);
            else if (wr_en && (wr_addr == AW'(g)))
                mem_q[g] <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = mem_q[g];
    end

    always_comb begin
        rd_byte = 8'h00;
        if (int'(rd_addr) < NREG) rd_byte = mem_q[rd_addr];
    end

    AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NREG)); // R5

endmodule

// File: rtl/spi_cmd_ready.sv
module spi_cmd_ready #(
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_updating,
    input  logic             done,
    output logic [RES_W-1:0] hold,
    output logic             drdy_n
);

    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            hold      <= '0;
        end else begin
            if (res_valid) hold <= res_data;
            if (res_updating)   pending_q <= 1'b0;
            else if (res_valid) pending_q <= 1'b1;
            else if (done)      pending_q <= 1'b0;
        end
    end

    assign drdy_n = ~pending_q;

    AST_UPDATE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        res_updating |=> drdy_n); // R8
    AST_STROBE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_updating) |=> !drdy_n); // R6
    AST_DONE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_valid && !res_updating) |=> drdy_n); // R7

endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
    import spi_cmd_pkg::*;
#(
    parameter int NREG   = 11,
    parameter int RES_W  = 24,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_updating,
    output logic              data_ready_n,
    output logic [NREG*8-1:0] cfg_regs
);

    localparam int            AW    = $clog2(NREG);
    localparam int            BW    = $clog2(RES_W);
    localparam logic [BW-1:0] LAST  = BW'(RES_W - 1);
    localparam logic [AW-1:0] ATOP  = AW'(NREG - 1);

    // pin synchronizers: {csn, sclk, mosi}
    logic [2:0] pins_s;
    spi_cmd_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_sclk, spi_mosi}),
        .q     (pins_s)
    );

    logic cs_on, sclk_s, mosi_s, sclk_d;
    assign cs_on  = ~pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    logic rise_evt, fall_evt;
    assign rise_evt = cs_on &  sclk_s & ~sclk_d;
    assign fall_evt = cs_on & ~sclk_s &  sclk_d;

    // state
    fsm_state_t    state_q, state_d;
    logic [BW-1:0] bit_q, bit_d;
    logic [6:0]    sh_q, sh_d;
    logic [AW-1:0] addr_q, addr_d, left_q, left_d;
    logic          is_wr_q, is_wr_d, cont_q, cont_d;
    logic          wr_en, done;
    logic [7:0]    byte_now, rd_byte;
    logic [RES_W-1:0] hold;
    logic          order_lsb;

    assign byte_now  = {sh_q, mosi_s};
    assign order_lsb = cfg_regs[ORDER_BIT];

    spi_cmd_regbank #(.NREG(NREG), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (addr_q),
        .wr_data   (byte_now),
        .rd_addr   (addr_q),
        .rd_byte   (rd_byte),
        .regs_flat (cfg_regs)
    );

    spi_cmd_ready #(.RES_W(RES_W)) u_ready (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_updating (res_updating),
        .done         (done),
        .hold         (hold),
        .drdy_n       (data_ready_n)
    );

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
        return (a == ATOP) ? '0 : a + AW'(1);
    endfunction

    function automatic logic [AW-1:0] start_addr(input logic [3:0] nib);
        return (int'(nib) < NREG) ? AW'(nib) : '0;
    endfunction

    function automatic logic [AW-1:0] cap_count(input logic [7:0] b);
        return (int'(b) >= NREG) ? ATOP : AW'(b);
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        addr_d  = addr_q;
        left_d  = left_q;
        is_wr_d = is_wr_q;
        cont_d  = cont_q;
        wr_en   = 1'b0;
        done    = 1'b0;
        if (!cs_on) begin
            state_d = ST_CMD;                       // deselect
            bit_d   = '0;
        end else if (res_updating && state_q == ST_RES) begin
            state_d = ST_CMD;                       // update-abort
            bit_d   = '0;
        end else if (rise_evt) begin
            if (state_q == ST_CMD && bit_q == '0 && cont_q && !data_ready_n)
                state_d = ST_RES;                   // auto-result
        end else if (fall_evt) begin
            if (state_q == ST_RES) begin
                if (bit_q == LAST) begin
                    done    = 1'b1;
                    state_d = ST_CMD;               // result-end
                    bit_d   = '0;
                end else begin
                    bit_d = bit_q + BW'(1);
                end
            end else begin
                sh_d = byte_now[6:0];
                if (bit_q[2:0] != 3'd7) begin
                    bit_d = bit_q + BW'(1);
                end else begin
                    bit_d = '0;
                    unique case (state_q)
                        ST_CMD: begin
                            if (byte_now[7:4] == OPH_RREG || byte_now[7:4] == OPH_WREG) begin
                                addr_d  = start_addr(byte_now[3:0]);
                                is_wr_d = (byte_now[7:4] == OPH_WREG);
                                state_d = ST_CNT;           // open-burst
                            end else if (byte_now == OP_RDATA) begin
                                state_d = ST_RES;           // read-result
                            end else if (byte_now == OP_RDATAC) begin
                                cont_d = 1'b1;
                            end else if (byte_now == OP_SDATAC) begin
                                cont_d = 1'b0;
                            end
                        end
                        ST_CNT: begin
                            left_d  = cap_count(byte_now);
                            state_d = is_wr_q ? ST_WR : ST_RD; // count-write / count-read
                        end
                        ST_WR, ST_RD: begin
                            wr_en = (state_q == ST_WR);
                            if (left_q == '0) begin
                                state_d = ST_CMD;           // burst-end
                            end else begin
                                left_d = left_q - AW'(1);
                                addr_d = next_addr(addr_q);
                            end
                        end
                        default: state_d = ST_CMD;
                    endcase
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            bit_q   <= '0;
            sh_q    <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            is_wr_q <= 1'b0;
            cont_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            addr_q  <= addr_d;
            left_q  <= left_d;
            is_wr_q <= is_wr_d;
            cont_q  <= cont_d;
        end
    end

    // output: MISO bit for the state being entered at this rising edge
    logic [BW-1:0] res_idx;
    logic          out_bit;
    always_comb begin
        res_idx = order_lsb ? bit_q : (LAST - bit_q);
        unique case (state_d)
            ST_RD:   out_bit = rd_byte[~bit_q[2:0]];
            ST_RES:  out_bit = hold[res_idx];
            default: out_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        spi_miso <= 1'b0;
        else if (!cs_on)   spi_miso <= 1'b0;
        else if (rise_evt) spi_miso <= out_bit;
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_on |=> (state_q == ST_CMD && bit_q == '0)); // R2
    AST_BYTE_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RES) |-> (bit_q < BW'(8))); // R2
    AST_RESULT_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RES) |-> (bit_q <= LAST)); // R7
    AST_BURST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD || state_q == ST_WR) |-> (left_q <= ATOP && addr_q <= ATOP)); // R4

endmodule

// File: tb/spi_cmd_regfile_tb.sv
module spi_cmd_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NREG       = 11;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso;
    logic res_valid = 1'b0, res_updating = 1'b0;
    logic [23:0] res_data = '0;
    logic data_ready_n;
    logic [NREG*8-1:0] cfg_regs;

    spi_cmd_regfile u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_csn      (spi_csn),
        .spi_sclk     (spi_sclk),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_updating (res_updating),
        .data_ready_n (data_ready_n),
        .cfg_regs     (cfg_regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] exp_regs [NREG];

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++; checks++;
            $display("FAIL watchdog: cycles %0d, expected fewer than %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int k = 0; k < NREG; k++) chk(req, 32'(cfg_regs[k*8 +: 8]), 32'(exp_regs[k]));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk); spi_csn = 1'b0; idle(4);
    endtask

    task automatic cs_high();
        idle(4); spi_csn = 1'b1; idle(4);
    endtask

    task automatic spi_bit(input logic tx, output logic rx);
        @(negedge clk); spi_mosi = tx; spi_sclk = 1'b1;
        idle(HALF);
        rx = spi_miso; spi_sclk = 1'b0;
        idle(HALF);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
    endtask

    task automatic spi_shift(input int n, output logic [23:0] rx);
        logic b;
        rx = '0;
        for (int i = 0; i < n; i++) begin
            spi_bit(1'b0, b);
            rx = {rx[22:0], b};
        end
    endtask

    task automatic strobe(input logic [23:0] d);
        @(negedge clk); res_valid = 1'b1; res_data = d;
        @(negedge clk); res_valid = 1'b0;
        idle(2);
    endtask

    task automatic wreg(input int a, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, input int n);
        logic [7:0] r;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        cs_low();
        spi_byte({4'h5, 4'(a)}, r);
        spi_byte(8'(n - 1), r);
        for (int i = 0; i < n; i++) begin
            spi_byte(dv[i], r);
            exp_regs[(a + i) % NREG] = dv[i];
        end
        cs_high();
    endtask

    function automatic logic [23:0] rev24(input logic [23:0] v);
        logic [23:0] o;
        for (int i = 0; i < 24; i++) o[i] = v[23 - i];
        return o;
    endfunction

    task automatic t_reset();
        for (int k = 0; k < NREG; k++) exp_regs[k] = (k == 3) ? 8'hF0 : 8'h00;
        chk("R1 drdy", 32'(data_ready_n), 32'd1);
        chk("R1 miso", 32'(spi_miso), 32'd0);
        chk_regs("R1 regs");
    endtask

    task automatic t_write();
        wreg(1, 8'h11, 8'h22, 8'h33, 3);
        chk_regs("R5 burst write");
    endtask

    task automatic t_read_wrap();
        logic [7:0] r;
        wreg(9, 8'hA9, 8'hAA, 8'hA0, 3);
        chk_regs("R4 write wrap");
        cs_low();
        spi_byte(8'h19, r);
        spi_byte(8'h03, r);
        for (int i = 0; i < 4; i++) begin
            spi_byte(8'h00, r);
            chk("R4 read wrap", 32'(r), 32'(exp_regs[(9 + i) % NREG]));
        end
        cs_high();
        cs_low();
        spi_byte(8'h1E, r);
        spi_byte(8'h00, r);
        spi_byte(8'h00, r);
        chk("R4 start past top", 32'(r), 32'(exp_regs[0]));
        cs_high();
    endtask

    task automatic t_read_cap();
        logic [7:0] r;
        cs_low();
        spi_byte(8'h10, r);
        spi_byte(8'h20, r);
        for (int i = 0; i < NREG; i++) begin
            spi_byte(8'h00, r);
            chk("R3 burst read", 32'(r), 32'(exp_regs[i]));
        end
        spi_byte(8'h00, r);
        chk("R3 cap at 11", 32'(r), 32'd0);
        cs_high();
    endtask

    task automatic t_cs_abort();
        logic [7:0] r;
        logic b;
        cs_low();
        for (int i = 0; i < 4; i++) spi_bit(1'b1, b);
        cs_high();
        cs_low();
        spi_byte(8'h13, r);
        spi_byte(8'h00, r);
        spi_byte(8'h00, r);
        chk("R2 abort partial byte", 32'(r), 32'(exp_regs[3]));
        cs_high();
    endtask

    task automatic t_rdata();
        logic [7:0] r;
        logic [23:0] d;
        strobe(24'h123456);
        chk("R6 drdy low", 32'(data_ready_n), 32'd0);
        cs_low();
        spi_byte(8'h01, r);
        spi_shift(24, d);
        chk("R7 result msb first", 32'(d), 32'h123456);
        chk("R7 drdy high after 24", 32'(data_ready_n), 32'd1);
        cs_high();
    endtask

    task automatic t_updating();
        strobe(24'h0A0B0C);
        chk("R8 pending", 32'(data_ready_n), 32'd0);
        @(negedge clk); res_updating = 1'b1;
        idle(2);
        chk("R8 forced high", 32'(data_ready_n), 32'd1);
        res_updating = 1'b0;
        idle(3);
        chk("R8 pending dropped", 32'(data_ready_n), 32'd1);
    endtask

    task automatic t_order();
        logic [7:0] r;
        logic [23:0] d;
        wreg(0, 8'h08, 8'h00, 8'h00, 1);
        strobe(24'hABCDEF);
        cs_low();
        spi_byte(8'h01, r);
        spi_shift(24, d);
        chk("R9 lsb first", 32'(rev24(d)), 32'hABCDEF);
        cs_high();
        wreg(0, 8'h00, 8'h00, 8'h00, 1);
    endtask

    task automatic t_continuous();
        logic [7:0] r;
        logic [23:0] d;
        cs_low(); spi_byte(8'h03, r); cs_high();
        strobe(24'h0F0F0F);
        cs_low();
        spi_shift(24, d);
        chk("R10 continuous data", 32'(d), 32'h0F0F0F);
        chk("R10 drdy high after 24", 32'(data_ready_n), 32'd1);
        cs_high();
        strobe(24'h765432);
        cs_low();
        spi_shift(8, d);
        chk("R11 partial first byte", 32'(d[7:0]), 32'h76);
        cs_high();
        chk("R11 drdy stays low", 32'(data_ready_n), 32'd0);
        @(negedge clk); res_updating = 1'b1;
        idle(2);
        res_updating = 1'b0;
        strobe(24'h111111);
        cs_low();
        spi_shift(24, d);
        chk("R11 next result from start", 32'(d), 32'h111111);
        cs_high();
        cs_low(); spi_byte(8'h0F, r); cs_high();
        strobe(24'h222222);
        cs_low();
        spi_byte(8'h00, r);
        chk("R12 stopped, miso", 32'(r), 32'd0);
        chk("R12 stopped, drdy", 32'(data_ready_n), 32'd0);
        spi_byte(8'hEE, r);
        chk("R12 unknown opcode out", 32'(r), 32'd0);
        cs_high();
        chk_regs("R12 unknown opcode regs");
    endtask

    task automatic t_conflict();
        logic [7:0] r;
        logic [23:0] d;
        logic b;
        strobe(24'h0000AA);
        cs_low();
        spi_byte(8'h01, r);
        spi_shift(23, d);
        @(negedge clk); spi_sclk = 1'b1;
        idle(HALF);
        b = spi_miso;
        spi_sclk = 1'b0;
        @(negedge clk);
        @(negedge clk); res_valid = 1'b1; res_data = 24'h5A5A5A;
        @(negedge clk); res_valid = 1'b0;
        idle(HALF);
        chk("R13 old word", 32'({d[22:0], b}), 32'h0000AA);
        chk("R13 drdy stays low", 32'(data_ready_n), 32'd0);
        cs_high();
        cs_low();
        spi_byte(8'h01, r);
        spi_shift(24, d);
        chk("R13 new word", 32'(d), 32'h5A5A5A);
        chk("R13 drdy after read", 32'(data_ready_n), 32'd1);
        cs_high();
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_write();
        t_read_wrap();
        t_read_cap();
        t_cs_abort();
        t_rdata();
        t_updating();
        t_order();
        t_continuous();
        t_conflict();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule